// File: doc/BRIEF.md
# Two-Cycle Fused-Pair Issue Scheduler

This block is an out-of-order issue queue whose wakeup/select loop is pipelined over two cycles. Each queue entry holds either one single-cycle instruction or a fused pair of dependent single-cycle instructions. A fused pair has one wakeup, one destination tag and up to three distinct source tags. The scheduler treats a fused entry as a non-pipelined two-cycle operation. It is selected once, broadcasts its tag once, and then a two-slot payload store sends the head and tail instructions to the same execution port on consecutive cycles.

Rename logic inserts one entry per cycle. Each inserted entry carries its source tags and their current ready bits, a destination tag, and the two payload slots. The select logic picks up to `NPORT` ready entries per cycle, oldest first, and assigns them to the free execution ports. Results produced outside the queue, such as loads, are announced through a single external tag broadcast. A dependent of a plain entry leaves a one-cycle bubble behind its parent, because the loop takes two cycles. A dependent of a fused entry issues in the cycle right after the tail, so dependent execution stays back-to-back.

Top module: `mop_iq_sched`

## Requirements
- R1: While reset is held and after its release, all `iss_vld_o` bits are 0 and `ins_rdy_o` is 1.
- R2: An entry is selected only once all three of its source ready bits are set. A fused entry therefore waits on every source of both halves.
- R3: An entry inserted in cycle c with all sources ready is selected in c+1. An entry selected in cycle n puts its head payload on a port in n+1, with `iss_tail_o` 0. A plain dependent of a plain entry puts out its head exactly two cycles after its parent's head when nothing else competes.
- R4: A fused entry selected in cycle n puts out its head in n+1 with `iss_tail_o`=0. It puts out its tail payload on the same port in n+2 with `iss_tail_o`=1. A dependent of the fused entry puts out its head in n+3.
- R5: A selection produces exactly one destination-tag broadcast, in the head cycle. The tail cycle broadcasts nothing.
- R6: A port that is putting out a fused head receives no new selection in that cycle. Younger ready entries wait for a free port.
- R7: Up to `NPORT` (4) entries are selected per cycle, in insertion order, independent of which slot an entry occupies. The k-th oldest selected entry goes to the k-th lowest-numbered free port.
- R8: An external broadcast in cycle m readies matching sources. An entry whose other sources are ready puts out its head in m+2.
- R9: A source tag that matches any broadcast, internal or external, in the cycle of its insertion is captured as ready.
- R10: The queue holds `DEPTH` (32) entries, and `ins_rdy_o` is 0 while all of them are occupied. An entry selected in cycle n makes `ins_rdy_o` 1 in cycle n+1.
- R11: Every accepted entry puts out its head exactly once. A fused entry puts out its tail exactly once, and a plain entry puts out no tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ins_vld_i | input | 1 | Insert request, accepted when `ins_rdy_o` is 1 |
| ins_fused_i | input | 1 | Entry carries a head/tail pair |
| ins_src_tag_i | input | 3x6 | Source tags of the entry |
| ins_src_rdy_i | input | 3 | Source ready bits at insertion (set for unused sources) |
| ins_dst_vld_i | input | 1 | Entry produces a result tag |
| ins_dst_tag_i | input | 6 | Result tag broadcast on selection |
| ins_head_i | input | 16 | Head instruction payload |
| ins_tail_i | input | 16 | Tail instruction payload (fused entries) |
| ins_rdy_o | output | 1 | At least one free entry |
| ext_wb_vld_i | input | 1 | External result tag valid |
| ext_wb_tag_i | input | 6 | External result tag |
| iss_vld_o | output | 4 | Port carries an instruction this cycle |
| iss_tail_o | output | 4 | Port carries the tail half of a fused entry |
| iss_pl_o | output | 4x16 | Instruction payload per port |

## Verification
Directed dependent chains contrast a plain parent with a fused parent. The dependent's head appears two cycles after a plain parent's head, and one cycle after a fused parent's tail, which separates the two wakeup paths. Batches that all wake on one external tag test several things at once. One batch mixes freed and reused slots, so age order and slot order differ. Another runs four fused entries ahead of plain ones, so a grant to a busy port would show up as an early head. Together these batches check oldest-first port assignment, port blocking and external wakeup. A full fill shows the insert-ready flag dropping and then returning one cycle after selection. A seeded random dependency stream then checks exactly-once issue, same-port tails and minimum parent-to-child spacing across arbitrary mixes of fused and plain entries.

// File: rtl/mop_iq_pkg.sv
package mop_iq_pkg;
  localparam int TAG_W = 6;
  localparam int PL_W  = 16;
  localparam int NSRC  = 3;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [PL_W-1:0]  pl_t;

  typedef struct packed {
    logic                  fused;
    tag_t [NSRC-1:0]       src_tag;
    logic [NSRC-1:0]       src_rdy;
    logic                  dst_vld;
    tag_t                  dst_tag;
    pl_t                   head;
    pl_t                   tail;
  } ent_t;
endpackage

// File: rtl/mop_iq_entry.sv
module mop_iq_entry import mop_iq_pkg::*; #(
  parameter int NBC = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  ent_t             ins_i,
  input  logic [NBC-1:0]   bc_vld_i,
  input  tag_t [NBC-1:0]   bc_tag_i,
  input  logic             issue_i,
  output logic             vld_o,
  output logic             req_o,
  output ent_t             ent_o
);
  logic            vld_q;
  ent_t            ent_q;
  logic [NSRC-1:0] wake_cur, wake_ins;

  always_comb begin
    wake_cur = '0;
    wake_ins = '0;
    for (int s = 0; s < NSRC; s++) begin
      for (int b = 0; b < NBC; b++) begin
        if (bc_vld_i[b] && bc_tag_i[b] == ent_q.src_tag[s]) wake_cur[s] = 1'b1;
        if (bc_vld_i[b] && bc_tag_i[b] == ins_i.src_tag[s]) wake_ins[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ent_q <= '0;
    end else if (alloc_i) begin
      vld_q         <= 1'b1;
      ent_q         <= ins_i;
      ent_q.src_rdy <= ins_i.src_rdy | wake_ins;
    end else begin
      if (issue_i) vld_q <= 1'b0;
      ent_q.src_rdy <= ent_q.src_rdy | wake_cur;
    end
  end

  assign vld_o = vld_q;
  assign req_o = vld_q && (&ent_q.src_rdy);
  assign ent_o = ent_q;
endmodule

// File: rtl/mop_iq_age.sv
module mop_iq_age #(
  parameter int DEPTH = 32,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        alloc_i,
  input  logic [IDX_W-1:0]            alloc_idx_i,
  input  logic [DEPTH-1:0]            vld_i,
  output logic [DEPTH-1:0][DEPTH-1:0] older_o
);
  // older_o[i][j]: entry j was inserted before entry i
  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          older_o[i][j] <= 1'b0;
        end else if (alloc_i) begin
          if (alloc_idx_i == IDX_W'(i))      older_o[i][j] <= (i != j) && vld_i[j];
          else if (alloc_idx_i == IDX_W'(j)) older_o[i][j] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mop_iq_select.sv
module mop_iq_select #(
  parameter int DEPTH = 32,
  parameter int NPORT = 4,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             req_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older_i,
  input  logic [NPORT-1:0]             busy_i,
  output logic [NPORT-1:0]             gnt_vld_o,
  output logic [NPORT-1:0][IDX_W-1:0]  gnt_idx_o,
  output logic [DEPTH-1:0]             gnt_vec_o
);
  always_comb begin
    logic [DEPTH-1:0] rem;
    logic [DEPTH-1:0] pick;
    rem       = req_i;
    gnt_vec_o = '0;
    gnt_vld_o = '0;
    gnt_idx_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      pick = '0;
      if (!busy_i[p]) begin
        for (int i = 0; i < DEPTH; i++)
          pick[i] = rem[i] && ((older_i[i] & rem) == '0);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (pick[i]) begin
          gnt_vld_o[p] = 1'b1;
          gnt_idx_o[p] = IDX_W'(i);
        end
      end
      rem       = rem & ~pick;
      gnt_vec_o = gnt_vec_o | pick;
    end
  end
endmodule

// File: rtl/mop_iq_port.sv
module mop_iq_port import mop_iq_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  ent_t ent_i,
  output logic busy_o,
  output logic out_vld_o,
  output logic out_tail_o,
  output pl_t  out_pl_o,
  output logic bc_vld_o,
  output tag_t bc_tag_o
);
  logic pend_q;
  pl_t  tail_pl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      tail_pl_q  <= '0;
      out_vld_o  <= 1'b0;
      out_tail_o <= 1'b0;
      out_pl_o   <= '0;
      bc_vld_o   <= 1'b0;
      bc_tag_o   <= '0;
    end else if (gnt_i) begin
      out_vld_o  <= 1'b1;
      out_tail_o <= 1'b0;
      out_pl_o   <= ent_i.head;
      pend_q     <= ent_i.fused;
      tail_pl_q  <= ent_i.tail;
      bc_vld_o   <= ent_i.dst_vld;
      bc_tag_o   <= ent_i.dst_tag;
    end else if (pend_q) begin
      out_vld_o  <= 1'b1;
      out_tail_o <= 1'b1;
      out_pl_o   <= tail_pl_q;
      pend_q     <= 1'b0;
      bc_vld_o   <= 1'b0;
    end else begin
      out_vld_o  <= 1'b0;
      out_tail_o <= 1'b0;
      bc_vld_o   <= 1'b0;
    end
  end

  // port held for the tail cycle of a fused pair
  assign busy_o = pend_q;
endmodule

// File: rtl/mop_iq_sched.sv
module mop_iq_sched import mop_iq_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int NPORT = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ins_vld_i,
  input  logic                        ins_fused_i,
  input  logic [NSRC-1:0][TAG_W-1:0]  ins_src_tag_i,
  input  logic [NSRC-1:0]             ins_src_rdy_i,
  input  logic                        ins_dst_vld_i,
  input  logic [TAG_W-1:0]            ins_dst_tag_i,
  input  logic [PL_W-1:0]             ins_head_i,
  input  logic [PL_W-1:0]             ins_tail_i,
  output logic                        ins_rdy_o,
  input  logic                        ext_wb_vld_i,
  input  logic [TAG_W-1:0]            ext_wb_tag_i,
  output logic [NPORT-1:0]            iss_vld_o,
  output logic [NPORT-1:0]            iss_tail_o,
  output logic [NPORT-1:0][PL_W-1:0]  iss_pl_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int NBC   = NPORT + 1;

  logic [DEPTH-1:0]            ent_vld, ent_req, gnt_vec;
  ent_t                        ent_arr [DEPTH];
  logic [DEPTH-1:0][DEPTH-1:0] older;
  logic [NPORT-1:0]            gnt_vld, port_busy, bc_vld_q;
  logic [NPORT-1:0][IDX_W-1:0] gnt_idx;
  tag_t [NPORT-1:0]            bc_tag_q;
  logic [NBC-1:0]              bc_vld;
  tag_t [NBC-1:0]              bc_tag;
  logic [IDX_W-1:0]            alloc_idx;
  logic                        alloc_en;
  ent_t                        ins_ent;

  always_comb begin
    alloc_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!ent_vld[i]) alloc_idx = IDX_W'(i);
  end

  assign ins_rdy_o = ~&ent_vld;
  assign alloc_en  = ins_vld_i && ins_rdy_o;

  always_comb begin
    ins_ent.fused   = ins_fused_i;
    ins_ent.src_tag = ins_src_tag_i;
    ins_ent.src_rdy = ins_src_rdy_i;
    ins_ent.dst_vld = ins_dst_vld_i;
    ins_ent.dst_tag = ins_dst_tag_i;
    ins_ent.head    = ins_head_i;
    ins_ent.tail    = ins_tail_i;
  end

  assign bc_vld = {ext_wb_vld_i, bc_vld_q};
  assign bc_tag = {ext_wb_tag_i, bc_tag_q};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    mop_iq_entry #(.NBC(NBC)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (alloc_en && (alloc_idx == IDX_W'(i))),
      .ins_i    (ins_ent),
      .bc_vld_i (bc_vld),
      .bc_tag_i (bc_tag),
      .issue_i  (gnt_vec[i]),
      .vld_o    (ent_vld[i]),
      .req_o    (ent_req[i]),
      .ent_o    (ent_arr[i])
    );
  end

  mop_iq_age #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_i     (alloc_en),
    .alloc_idx_i (alloc_idx),
    .vld_i       (ent_vld),
    .older_o     (older)
  );

  mop_iq_select #(.DEPTH(DEPTH), .NPORT(NPORT), .IDX_W(IDX_W)) u_sel (
    .req_i     (ent_req),
    .older_i   (older),
    .busy_i    (port_busy),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx),
    .gnt_vec_o (gnt_vec)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    mop_iq_port u_port (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .gnt_i      (gnt_vld[p]),
      .ent_i      (ent_arr[gnt_idx[p]]),
      .busy_o     (port_busy[p]),
      .out_vld_o  (iss_vld_o[p]),
      .out_tail_o (iss_tail_o[p]),
      .out_pl_o   (iss_pl_o[p]),
      .bc_vld_o   (bc_vld_q[p]),
      .bc_tag_o   (bc_tag_q[p])
    );
  end
endmodule

// File: rtl/mop_iq_sched_chk.sv
module mop_iq_sched_chk #(
  parameter int DEPTH = 32,
  parameter int NPORT = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NPORT-1:0] iss_vld_o,
  input logic [NPORT-1:0] iss_tail_o,
  input logic [NPORT-1:0] port_busy,
  input logic [NPORT-1:0] gnt_vld,
  input logic [NPORT-1:0] bc_vld_q,
  input logic [DEPTH-1:0] gnt_vec,
  input logic [DEPTH-1:0] ent_req,
  input logic [DEPTH-1:0] ent_vld,
  input logic             ins_rdy_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_p
    AST_TAIL_AFTER_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_tail_o[p] |-> $past(iss_vld_o[p] && !iss_tail_o[p])); // R4
    AST_BUSY_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      port_busy[p] |-> !gnt_vld[p]); // R6
    AST_TAIL_NO_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_tail_o[p] |-> !bc_vld_q[p]); // R5
  end

  AST_GNT_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vec & ~ent_req) == '0); // R2
  AST_GNT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gnt_vec) == $countones(gnt_vld)); // R7
  AST_FULL_NO_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(ent_vld) == DEPTH) |-> !ins_rdy_o); // R10
  AST_FREED_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vec != '0) |=> ins_rdy_o); // R10
endmodule

bind mop_iq_sched mop_iq_sched_chk #(.DEPTH(DEPTH), .NPORT(NPORT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .iss_vld_o  (iss_vld_o),
  .iss_tail_o (iss_tail_o),
  .port_busy  (port_busy),
  .gnt_vld    (gnt_vld),
  .bc_vld_q   (bc_vld_q),
  .gnt_vec    (gnt_vec),
  .ent_req    (ent_req),
  .ent_vld    (ent_vld),
  .ins_rdy_o  (ins_rdy_o)
);

// File: tb/mop_iq_sched_tb_top.sv
module mop_iq_sched_tb_top;
  import mop_iq_pkg::*;
  localparam int NPORT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_vld = 1'b0, ins_fused = 1'b0, ins_dst_vld = 1'b0;
  logic [NSRC-1:0][TAG_W-1:0] ins_src_tag = '0;
  logic [NSRC-1:0] ins_src_rdy = '0;
  logic [TAG_W-1:0] ins_dst_tag = '0, ext_tag = '0;
  logic [PL_W-1:0] ins_head = '0, ins_tail = '0;
  logic ext_vld = 1'b0;
  logic ins_rdy;
  logic [NPORT-1:0] iss_vld, iss_tail;
  logic [NPORT-1:0][PL_W-1:0] iss_pl;

  always #2 clk = ~clk;

  mop_iq_sched #(.DEPTH(32), .NPORT(NPORT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ins_vld_i(ins_vld), .ins_fused_i(ins_fused), .ins_src_tag_i(ins_src_tag),
    .ins_src_rdy_i(ins_src_rdy), .ins_dst_vld_i(ins_dst_vld), .ins_dst_tag_i(ins_dst_tag),
    .ins_head_i(ins_head), .ins_tail_i(ins_tail), .ins_rdy_o(ins_rdy),
    .ext_wb_vld_i(ext_vld), .ext_wb_tag_i(ext_tag),
    .iss_vld_o(iss_vld), .iss_tail_o(iss_tail), .iss_pl_o(iss_pl)
  );

  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  int head_cyc[128], tail_cyc[128], head_port[128], tail_port[128];
  int head_cnt[128], tail_cnt[128], ins_cyc[128], par[128][3];
  bit is_fused[128];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // monitor: payload bit 15 marks a tail, bits 6:0 carry the bench id
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NPORT; p++) begin
        if (iss_vld[p]) begin
          int id;
          id = int'(iss_pl[p][6:0]);
          if (int'(iss_tail[p]) != int'(iss_pl[p][PL_W-1]))
            chk("R4 tail flag", int'(iss_tail[p]), int'(iss_pl[p][PL_W-1]));
          if (iss_tail[p]) begin
            tail_cnt[id]++; tail_cyc[id] = cyc; tail_port[id] = p;
          end else begin
            head_cnt[id]++; head_cyc[id] = cyc; head_port[id] = p;
          end
        end
      end
    end
  end

  task automatic ins(input int id, input bit fz, input int t0, t1, t2,
                     input bit r0, r1, r2, input bit dv, input int dt);
    ins_vld = 1'b1; ins_fused = fz;
    ins_src_tag[0] = TAG_W'(t0); ins_src_tag[1] = TAG_W'(t1); ins_src_tag[2] = TAG_W'(t2);
    ins_src_rdy = {r2, r1, r0};
    ins_dst_vld = dv; ins_dst_tag = TAG_W'(dt);
    ins_head = {1'b0, (PL_W-1)'(id)};
    ins_tail = {1'b1, (PL_W-1)'(id)};
    ins_cyc[id] = cyc; is_fused[id] = fz;
    @(negedge clk);
    ins_vld = 1'b0;
  endtask

  task automatic ext(input int t, output int e);
    ext_vld = 1'b1; ext_tag = TAG_W'(t); e = cyc;
    @(negedge clk);
    ext_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int e;
    for (int i = 0; i < 128; i++) begin
      head_cnt[i] = 0; tail_cnt[i] = 0;
      for (int s = 0; s < 3; s++) par[i][s] = -1;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 iss_vld in reset", int'(iss_vld), 0);
    chk("R1 ins_rdy in reset", int'(ins_rdy), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 iss_vld after reset", int'(iss_vld), 0);
    chk("R1 ins_rdy after reset", int'(ins_rdy), 1);

    // R3: plain parent, plain dependent
    ins(1, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    ins(2, 0, 1, 0, 0, 0, 1, 1, 0, 0);
    idle(6);
    chk("R3 head two after insert", head_cyc[1], ins_cyc[1] + 2);
    chk("R3 dependent gap", head_cyc[2], head_cyc[1] + 2);
    chk("R11 plain no tail", tail_cnt[1], 0);

    // R4: fused parent, dependent back-to-back after tail
    ins(3, 1, 0, 0, 0, 1, 1, 1, 1, 3);
    ins(4, 0, 3, 0, 0, 0, 1, 1, 0, 0);
    idle(6);
    chk("R4 fused head", head_cyc[3], ins_cyc[3] + 2);
    chk("R4 tail next cycle", tail_cyc[3], head_cyc[3] + 1);
    chk("R4 tail same port", tail_port[3], head_port[3]);
    chk("R4 dependent after tail", head_cyc[4], tail_cyc[3] + 1);

    // R2 / R8: fused entry waits on its last source, then external wake
    ins(5, 1, 10, 11, 12, 1, 1, 0, 0, 0);
    idle(4);
    chk("R2 not issued while a source is pending", head_cnt[5], 0);
    ext(12, e);
    idle(4);
    chk("R8 head two after external tag", head_cyc[5], e + 2);
    chk("R8 tail follows", tail_cyc[5], e + 3);

    // R9: tag broadcast in the insertion cycle
    ext_vld = 1'b1; ext_tag = TAG_W'(20);
    ins(6, 0, 20, 0, 0, 0, 1, 1, 0, 0);
    ext_vld = 1'b0;
    idle(4);
    chk("R9 capture on insert", head_cyc[6], ins_cyc[6] + 2);

    // R7: age order differs from slot order
    for (int i = 10; i <= 12; i++) ins(i, 0, 41, 0, 0, 0, 1, 1, 0, 0);
    for (int i = 13; i <= 18; i++) ins(i, 0, 30, 0, 0, 0, 1, 1, 0, 0);
    ext(41, e);
    idle(3);
    ins(19, 0, 30, 0, 0, 0, 1, 1, 0, 0);
    idle(2);
    ext(30, e);
    idle(5);
    for (int i = 13; i <= 16; i++) begin
      chk("R7 first batch cycle", head_cyc[i], e + 2);
      chk("R7 first batch port", head_port[i], i - 13);
    end
    for (int i = 17; i <= 19; i++) begin
      chk("R7 second batch cycle", head_cyc[i], e + 3);
      chk("R7 second batch port", head_port[i], i - 17);
    end

    // R6: fused entries hold all ports for the tail cycle
    for (int i = 20; i <= 23; i++) ins(i, 1, 50, 0, 0, 0, 1, 1, 0, 0);
    ins(24, 0, 50, 0, 0, 0, 1, 1, 0, 0);
    ins(25, 0, 50, 0, 0, 0, 1, 1, 0, 0);
    ext(50, e);
    idle(6);
    for (int i = 20; i <= 23; i++) chk("R6 fused tail cycle", tail_cyc[i], e + 3);
    chk("R6 plain waits for port", head_cyc[24], e + 4);
    chk("R6 plain waits for port", head_cyc[25], e + 4);
    chk("R6 plain port", head_port[25], 1);

    // R10: fill and release
    for (int i = 30; i <= 61; i++) ins(i, 0, 60, 0, 0, 0, 1, 1, 0, 0);
    chk("R10 full", int'(ins_rdy), 0);
    ext(60, e);
    chk("R10 full before first select", int'(ins_rdy), 0);
    @(negedge clk);
    chk("R10 free cycle after select", int'(ins_rdy), 1);
    idle(12);
    for (int i = 30; i <= 61; i++) chk("R11 fill drained", head_cnt[i], 1);

    // random dependency stream
    for (int k = 64; k < 124; k++) begin
      int t[3];
      bit r[3];
      bit fz;
      fz = 1'($urandom % 2);
      for (int s = 0; s < 3; s++) begin
        if (k > 64 && ($urandom % 3) != 0) begin
          par[k][s] = 64 + int'($urandom % (k - 64));
          t[s] = par[k][s] - 64;
          r[s] = (head_cnt[par[k][s]] > 0);
        end else begin
          par[k][s] = -1; t[s] = 0; r[s] = 1'b1;
        end
      end
      while (!ins_rdy) @(negedge clk);
      ins(k, fz, t[0], t[1], t[2], r[0], r[1], r[2], 1'b1, k - 64);
      idle(int'($urandom % 3));
    end
    idle(60);
    for (int k = 64; k < 124; k++) begin
      chk("R11 head once", head_cnt[k], 1);
      chk("R11 tail count", tail_cnt[k], is_fused[k] ? 1 : 0);
      if (is_fused[k]) begin
        chk("R4 random tail cycle", tail_cyc[k], head_cyc[k] + 1);
        chk("R4 random tail port", tail_port[k], head_port[k]);
      end
      chk("R3 no issue before insert+2", int'(head_cyc[k] >= ins_cyc[k] + 2), 1);
      for (int s = 0; s < 3; s++)
        if (par[k][s] >= 0)
          chk("R2 child after parent wake", int'(head_cyc[k] >= head_cyc[par[k][s]] + 2), 1);
    end

    summary();
    $finish;
  end
endmodule